// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a synchronous dual-port RAM in which either side, left or right, can read or write any word independently. Two words at the top of the address space also serve as mailboxes between the two sides. Writing the top word from the left raises the right side's interrupt. Writing the word just below it from the right raises the left side's interrupt. Each interrupt stays raised until the side that owns it reads the same mailbox word.

There are no interrupt registers. The flags change only as side effects of normal reads and writes to the two reserved addresses. The mailbox words hold whatever software writes into them, exactly like any other word.

Each side has an enable, a write strobe, an output enable, an address, write data and registered read data. The memory depth follows the address-width parameter. A width of 13 gives the 8192-word configuration, and the default is kept smaller. The word width defaults to 9 bits. Both sides share one clock. The reset input is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `mbx_dualport`

## Requirements
- R1: After reset both interrupt outputs `l_irq_n` and `r_irq_n` are high (inactive). Both are driven actively in either state.
- R2: A left write (`l_en`=1, `l_we`=1) to the all-ones address drives `r_irq_n` low after that clock edge.
- R3: A right read (`r_en`=1, `r_oe`=1, `r_we`=0) of the all-ones address returns `r_irq_n` high after that edge.
- R4: A right write to the all-ones-minus-one address drives `l_irq_n` low after that edge.
- R5: A left read of the all-ones-minus-one address returns `l_irq_n` high after that edge.
- R6: When a flag is set and cleared on the same edge, the set wins and the flag ends up low.
- R7: Mailbox words are ordinary storage. A read returns the data last written. Accesses to other addresses leave both flags unchanged. A read of a mailbox by the side that does not own its flag does not clear that flag.
- R8: A read takes place only when enable and output enable are both high and the write strobe is low. Otherwise the read data holds its value and no flag is cleared.
- R9: When one side reads an address on the same edge that the other side writes it, the read returns the old word. A read on the following cycle returns the new word.
- R10: A read returns data one cycle later. A word written from one side can be read from the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_en | input | 1 | Left access enable |
| l_we | input | 1 | Left write strobe |
| l_oe | input | 1 | Left output enable |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| r_en | input | 1 | Right access enable |
| r_we | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The assertions assume that the two sides never write the same address on the same edge, since that collision is not resolved. They also assume that accesses begin only after the internal reset has been released. The directed stimulus writes the two sides to different words whenever both write, and it waits several cycles after reset before its first access. Same-edge collisions occur only as a read on one side against a write on the other. These collisions are used to check that old data is returned and that a set of a flag wins over its clear.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned SIDES = 2;
  localparam int unsigned SIDE_L = 0;
  localparam int unsigned SIDE_R = 1;

  function automatic int unsigned other_side(input int unsigned s);
    return (s == SIDE_L) ? SIDE_R : SIDE_L;
  endfunction
endpackage

// File: rtl/mbx_rstsync.sv
module mbx_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/mbx_ram.sv
module mbx_ram #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 9,
  parameter int unsigned PORTS  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [PORTS-1:0]              wr,
  input  logic [PORTS-1:0]              rd,
  input  logic [PORTS-1:0][ADDR_W-1:0]  addr,
  input  logic [PORTS-1:0][DATA_W-1:0]  wdata,
  output logic [PORTS-1:0][DATA_W-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int p = 0; p < PORTS; p++) begin
      if (wr[p]) mem[addr[p]] <= wdata[p];
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    logic [DATA_W-1:0] rd_d, rd_q;

    always_comb begin
      rd_d = rd_q;
      if (rd[p]) rd_d = mem[addr[p]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd[p]) rd_q <= rd_d;
    end

    assign rdata[p] = rd_q;
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  logic pend_d, pend_q;

  always_comb begin
    pend_d = pend_q;
    if (clr) pend_d = 1'b0;
    if (set) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign irq_n = ~pend_q;
endmodule

// File: rtl/mbx_dualport.sv
module mbx_dualport #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_en,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              l_irq_n,
  output logic              r_irq_n
);
  import mbx_pkg::*;

  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] INBOX_R  = TOP_ADDR;
  localparam logic [ADDR_W-1:0] INBOX_L  = TOP_ADDR - 1'b1;

  logic rst_q_n;
  logic [SIDES-1:0]             en, we, oe, wr, rd;
  logic [SIDES-1:0][ADDR_W-1:0] addr, inbox;
  logic [SIDES-1:0][DATA_W-1:0] wdata, rdata;
  logic [SIDES-1:0]             irq_n;

  mbx_rstsync i_rstsync (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  assign en    = {r_en, l_en};
  assign we    = {r_we, l_we};
  assign oe    = {r_oe, l_oe};
  assign addr  = {r_addr, l_addr};
  assign wdata = {r_wdata, l_wdata};
  assign inbox = {INBOX_R, INBOX_L};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam int unsigned OTHER = other_side(s);

    assign wr[s] = en[s] & we[s];
    assign rd[s] = en[s] & oe[s] & ~we[s];

    mbx_flag i_flag (
      .clk   (clk),
      .rst_n (rst_q_n),
      .set   (wr[OTHER] && (addr[OTHER] == inbox[s])),
      .clr   (rd[s] && (addr[s] == inbox[s])),
      .irq_n (irq_n[s])
    );
  end

  mbx_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORTS(SIDES)) i_ram (
    .clk   (clk),
    .rst_n (rst_q_n),
    .wr    (wr),
    .rd    (rd),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  assign l_rdata = rdata[SIDE_L];
  assign r_rdata = rdata[SIDE_R];
  assign l_irq_n = irq_n[SIDE_L];
  assign r_irq_n = irq_n[SIDE_R];
endmodule

// File: rtl/mbx_dualport_chk.sv
module mbx_dualport_chk #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 9
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              l_en,
  input logic              l_we,
  input logic              l_oe,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_rdata,
  input logic              r_en,
  input logic              r_we,
  input logic              r_oe,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_rdata,
  input logic              l_irq_n,
  input logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] HI = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] LO = HI - 1'b1;

  logic l_w, l_r, r_w, r_r, set_r, clr_r, set_l, clr_l;
  assign l_w   = l_en & l_we;
  assign r_w   = r_en & r_we;
  assign l_r   = l_en & l_oe & ~l_we;
  assign r_r   = r_en & r_oe & ~r_we;
  assign set_r = l_w && l_addr == HI;
  assign clr_r = r_r && r_addr == HI;
  assign set_l = r_w && r_addr == LO;
  assign clr_l = l_r && l_addr == LO;

  a_r2_left_write_raises_right: assert property (@(posedge clk) disable iff (!rst_q_n)
    set_r |=> !r_irq_n);
  a_r3_right_read_clears_right: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_r && !set_r) |=> r_irq_n);
  a_r4_right_write_raises_left: assert property (@(posedge clk) disable iff (!rst_q_n)
    set_l |=> !l_irq_n);
  a_r5_left_read_clears_left: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_l && !set_l) |=> l_irq_n);
  a_r6_set_wins_right: assert property (@(posedge clk) disable iff (!rst_q_n)
    (set_r && clr_r) |=> !r_irq_n);
  a_r7_right_flag_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!set_r && !clr_r) |=> $stable(r_irq_n));
  a_r7_left_flag_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!set_l && !clr_l) |=> $stable(l_irq_n));
  a_r8_left_rdata_holds: assert property (@(posedge clk) disable iff (!rst_q_n)
    !l_r |=> $stable(l_rdata));
  a_r8_right_rdata_holds: assert property (@(posedge clk) disable iff (!rst_q_n)
    !r_r |=> $stable(r_rdata));
endmodule

bind mbx_dualport mbx_dualport_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mbx_chk (
  .clk(clk), .rst_q_n(rst_q_n),
  .l_en(l_en), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_rdata(l_rdata),
  .r_en(r_en), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_rdata(r_rdata),
  .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
);

// File: tb/test_mbx_dualport.sv
`timescale 1ns/1ps
module test_mbx_dualport;
  localparam int unsigned AW = 11;
  localparam int unsigned DW = 9;
  localparam logic [AW-1:0] HI = {AW{1'b1}};
  localparam logic [AW-1:0] LO = HI - 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_en = 0, l_we = 0, l_oe = 0, r_en = 0, r_we = 0, r_oe = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0, l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mbx_dualport #(.ADDR_W(AW), .DATA_W(DW)) i_mbx_dualport (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_en(r_en), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one cycle with both sides driven; outputs sampled 1 ns after the edge
  task automatic cyc(input logic le, lw, lo, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                     input logic re, rw, ro, input logic [AW-1:0] ra, input logic [DW-1:0] rd);
    @(negedge clk);
    l_en = le; l_we = lw; l_oe = lo; l_addr = la; l_wdata = ld;
    r_en = re; r_we = rw; r_oe = ro; r_addr = ra; r_wdata = rd;
    @(posedge clk);
    #1;
    l_en = 0; l_we = 0; l_oe = 0; r_en = 0; r_we = 0; r_oe = 0;
  endtask

  task automatic t_reset();
    chk("R1 l_irq_n after reset", l_irq_n, 1);
    chk("R1 r_irq_n after reset", r_irq_n, 1);
  endtask

  task automatic t_plain_ram();
    cyc(1,1,0,11'd5,9'h1A5, 0,0,0,'0,'0);
    cyc(0,0,0,'0,'0, 1,0,1,11'd5,'0);
    chk("R10 cross-side read", r_rdata, 'h1A5);
    chk("R7 plain write leaves r_irq_n", r_irq_n, 1);
    chk("R7 plain write leaves l_irq_n", l_irq_n, 1);
  endtask

  task automatic t_right_irq();
    cyc(1,1,0,HI,9'h0AA, 0,0,0,'0,'0);
    chk("R2 left write raises r_irq_n", r_irq_n, 0);
    chk("R2 l_irq_n untouched", l_irq_n, 1);
    cyc(1,0,1,HI,'0, 0,0,0,'0,'0);
    chk("R7 left read of mailbox data", l_rdata, 'h0AA);
    chk("R7 non-owner read keeps r_irq_n", r_irq_n, 0);
    cyc(0,0,0,'0,'0, 1,0,0,HI,'0);
    chk("R8 no oe keeps r_irq_n", r_irq_n, 0);
    chk("R8 no oe keeps r_rdata", r_rdata, 'h1A5);
    cyc(0,0,0,'0,'0, 0,0,1,HI,'0);
    chk("R8 no en keeps r_irq_n", r_irq_n, 0);
    cyc(0,0,0,'0,'0, 1,0,1,HI,'0);
    chk("R3 right read data", r_rdata, 'h0AA);
    chk("R3 right read clears r_irq_n", r_irq_n, 1);
  endtask

  task automatic t_left_irq();
    cyc(0,0,0,'0,'0, 1,1,0,LO,9'h155);
    chk("R4 right write raises l_irq_n", l_irq_n, 0);
    chk("R4 r_irq_n untouched", r_irq_n, 1);
    cyc(0,0,0,'0,'0, 1,0,1,LO,'0);
    chk("R7 non-owner read keeps l_irq_n", l_irq_n, 0);
    cyc(1,0,1,LO,'0, 0,0,0,'0,'0);
    chk("R5 left read data", l_rdata, 'h155);
    chk("R5 left read clears l_irq_n", l_irq_n, 1);
  endtask

  task automatic t_collide();
    cyc(1,1,0,HI,9'h123, 1,0,1,HI,'0);
    chk("R6 set wins over clear", r_irq_n, 0);
    chk("R9 same-edge read old data", r_rdata, 'h0AA);
    cyc(0,0,0,'0,'0, 1,0,1,HI,'0);
    chk("R9 next-cycle read new data", r_rdata, 'h123);
    chk("R3 later read clears r_irq_n", r_irq_n, 1);
    cyc(1,0,1,11'd7,'0, 1,1,0,11'd7,9'h0F0);
    cyc(1,0,1,11'd7,'0, 0,0,0,'0,'0);
    chk("R9 left sees right write next cycle", l_rdata, 'h0F0);
    chk("R7 other address leaves l_irq_n", l_irq_n, 1);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_plain_ram();
    t_right_irq();
    t_left_irq();
    t_collide();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule